// File: doc/BRIEF.md
# DTMF Digit Qualifier and Serial Framer

This block sits after a dual-tone detector. The detector gives it a 4-bit key code and a flag that says a tone pair is present. The block decides when a key press counts as a real digit: the code must stay unchanged for long enough, and the line must have been silent for long enough since the previous digit. Once a digit is accepted, the block drives an active-low valid strobe low and shifts the digit out on one serial line. The frame carries the data nibble and a check nibble, both least significant bit first. When the stop bit has finished, the strobe returns high.

All timing comes from the clock. A prescaler makes one tick per millisecond, and the digit and pause windows are counted in those ticks. A separate baud counter sets how long each serial bit lasts. A power-down input forces both outputs high and returns every internal state to its reset value. The key codes pass through unchanged: keys 1 to 9 are codes 1 to 9, key 0 is 10, star is 11, hash is 12, and the letter keys A, B, C, D are 13, 14, 15 and 0.

Top module: `dtmf_digit_serializer`

## Requirements
- R1: A millisecond tick occurs every CYC_PER_MS clocks, counted from reset or from leaving power-down. A digit is accepted only once `tone_det` has stayed high with the same `tone_code` across STABLE_MS ticks. A tone that is shorter than this sends nothing.
- R2: The block starts out armed after reset. Sending a digit disarms it. It is armed again only after `tone_det` has stayed low across PAUSE_MS ticks. While it is disarmed, a new code, held however long, is not sent.
- R3: In the clock cycle after acceptance, `dvalid_n` goes low and the start bit (0) begins on `sdata_out`.
- R4: The frame has ten bits in this order: start 0, data bits D0 D1 D2 D3, check bits C0 C1 C2 C3, stop 1. The data nibble is `tone_code` unchanged, so key 0 sends the value 10.
- R5: The check nibble is (16 − data) mod 16. Data 0 gives check 0, and data 15 gives check 1.
- R6: Every bit lasts BAUD_DIV clocks. `dvalid_n` stays low for exactly 10·BAUD_DIV clocks and returns high when the stop bit ends. The default BAUD_DIV is CLK_HZ/1200.
- R7: A digit that is still held after its frame is not sent a second time.
- R8: While `pwr_down` is high, `dvalid_n` and `sdata_out` are high. A frame in progress is abandoned, and all state returns to its reset value.
- R9: When no frame is being sent, `sdata_out` idles high and `dvalid_n` is high.
- R10: If the code changes while `tone_det` stays high, the stability count starts again from zero for the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | Power-down: outputs forced high, state cleared |
| tone_det | input | 1 | A tone pair is present |
| tone_code | input | 4 | Key code from the tone detector |
| dvalid_n | output | 1 | Active-low strobe, low for the whole frame |
| sdata_out | output | 1 | Serial frame output, idles high |

## Verification
The bench goes after the timing edges of the qualifier:
- A tone that stops 10 ms short of the stability window. A block that counted too few ticks would send this phantom digit.
- A second key pressed after a gap that is shorter than the pause window. A block that re-armed too early would send it.
- A code that changes halfway through the window. A block that kept the old count would send the new code too soon.
- A digit held long after its frame. A block that did not disarm after sending would repeat it.

Frames are decoded bit by bit. This catches a reversed bit order, a wrong check nibble at codes 0, 10 and 15, and a stop bit that is cut short. Power-down is applied in the middle of a frame, to show that the outputs go high at once and the frame is not finished afterwards.

// File: rtl/dtmf_ser_pkg.sv
package dtmf_ser_pkg;
    localparam int FRAME_BITS = 10;

    typedef logic [3:0]            nib_t;
    typedef logic [FRAME_BITS-1:0] frame_t;

    // check nibble: two's complement of the data, modulo 16
    function automatic nib_t chk_of(input nib_t d);
        return (~d) + 4'd1;
    endfunction

    // index 0 is sent first: start, data LSB first, check LSB first, stop
    function automatic frame_t pack_frame(input nib_t d);
        return {1'b1, chk_of(d), d, 1'b0};
    endfunction
endpackage

// File: rtl/dtmf_ms_tick.sv
module dtmf_ms_tick #(
    parameter int CYC_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC_PER_MS - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == LAST);
        if (clr || tick) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dtmf_digit_gate.sv
module dtmf_digit_gate
    import dtmf_ser_pkg::*;
#(
    parameter int STABLE_MS = 40,
    parameter int PAUSE_MS  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic tone_det,
    input  nib_t tone_code,
    input  logic tx_busy,
    output logic accept,
    output nib_t acc_code
);
    localparam int RW = $clog2(STABLE_MS + 1);
    localparam int QW = $clog2(PAUSE_MS + 1);
    localparam logic [RW-1:0] RUN_FULL   = RW'(STABLE_MS);
    localparam logic [QW-1:0] QUIET_FULL = QW'(PAUSE_MS);

    typedef struct packed {
        nib_t          cand;
        logic          have;
        logic [RW-1:0] run;
        logic [QW-1:0] quiet;
        logic          armed;
    } st_t;

    localparam st_t RST = '{cand: 4'd0, have: 1'b0, run: '0, quiet: '0, armed: 1'b1};

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        accept   = st_q.armed && st_q.have && (st_q.run == RUN_FULL) && !tx_busy;
        acc_code = st_q.cand;

        if (tone_det) begin
            st_d.quiet = '0;
            if (!st_q.have || (tone_code != st_q.cand)) begin
                st_d.cand = tone_code;
                st_d.have = 1'b1;
                st_d.run  = '0;
            end else if (tick && (st_q.run != RUN_FULL)) begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.have = 1'b0;
            st_d.run  = '0;
            if (tick && (st_q.quiet != QUIET_FULL)) st_d.quiet = st_q.quiet + 1'b1;
            if (st_q.quiet == QUIET_FULL)           st_d.armed = 1'b1;
        end

        if (accept) st_d.armed = 1'b0;
        if (clr)    st_d = RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dtmf_frame_tx.sv
module dtmf_frame_tx
    import dtmf_ser_pkg::*;
#(
    parameter int BAUD_DIV = 41667
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  nib_t code,
    output logic busy,
    output logic line
);
    localparam int BW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] BAUD_LAST = BW'(BAUD_DIV - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(FRAME_BITS - 1);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        logic [BW-1:0] baud;
        frame_t        sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.baud == BAUD_LAST) begin
                st_d.baud = '0;
                if (st_q.idx == IDX_LAST) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                    st_d.sh  = {1'b1, st_q.sh[FRAME_BITS-1:1]};
                end
            end else begin
                st_d.baud = st_q.baud + 1'b1;
            end
        end else if (load) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.baud = '0;
            st_d.sh   = pack_frame(code);
        end
        if (clr) st_d = '0;
    end

    assign busy = st_q.busy;
    assign line = st_q.busy ? st_q.sh[0] : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dtmf_digit_serializer.sv
module dtmf_digit_serializer
    import dtmf_ser_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int BAUD       = 1200,
    parameter int CYC_PER_MS = CLK_HZ / 1000,
    parameter int BAUD_DIV   = CLK_HZ / BAUD,
    parameter int STABLE_MS  = 40,
    parameter int PAUSE_MS   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    input  logic       tone_det,
    input  logic [3:0] tone_code,
    output logic       dvalid_n,
    output logic       sdata_out
);
    logic tick, accept, tx_busy, tx_line;
    nib_t acc_code;

    dtmf_ms_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(pwr_down), .tick(tick)
    );

    dtmf_digit_gate #(.STABLE_MS(STABLE_MS), .PAUSE_MS(PAUSE_MS)) u_gate (
        .clk(clk), .rst_n(rst_n), .clr(pwr_down), .tick(tick),
        .tone_det(tone_det), .tone_code(tone_code), .tx_busy(tx_busy),
        .accept(accept), .acc_code(acc_code)
    );

    dtmf_frame_tx #(.BAUD_DIV(BAUD_DIV)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(pwr_down), .load(accept),
        .code(acc_code), .busy(tx_busy), .line(tx_line)
    );

    assign dvalid_n  = pwr_down | ~tx_busy;
    assign sdata_out = pwr_down | tx_line;
endmodule

// File: rtl/dtmf_digit_serializer_chk.sv
module dtmf_digit_serializer_chk #(
    parameter int BAUD_DIV = 16
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_down,
    input logic tone_det,
    input logic dvalid_n,
    input logic sdata_out
);
    int low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_cnt <= 0;
        else if (dvalid_n) low_cnt <= 0;
        else               low_cnt <= low_cnt + 1;
    end

    a_r8_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> dvalid_n);

    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dvalid_n) |-> !sdata_out);

    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid_n |-> sdata_out);

    a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dvalid_n) && !pwr_down) |-> $past(sdata_out));

    a_r6_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dvalid_n) && !pwr_down) |-> (low_cnt == 10 * BAUD_DIV));

    a_r1_needs_tone: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dvalid_n) |-> $past(tone_det, 2));
endmodule

bind dtmf_digit_serializer dtmf_digit_serializer_chk #(.BAUD_DIV(BAUD_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .tone_det(tone_det),
    .dvalid_n(dvalid_n), .sdata_out(sdata_out)
);

// File: tb/dtmf_digit_serializer_bench.sv
module dtmf_digit_serializer_bench;
    localparam int CPM = 20;
    localparam int SMS = 40;
    localparam int PMS = 20;
    localparam int BD  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b0;
    logic       tone_det = 1'b0;
    logic [3:0] tone_code = 4'd0;
    logic       dvalid_n, sdata_out;

    int errors = 0;
    int checks = 0;
    int frames = 0;
    int cur_code = 0;
    string cur_req = "R9";

    always #10 clk = ~clk;

    dtmf_digit_serializer #(
        .CLK_HZ(1_000_000), .CYC_PER_MS(CPM), .BAUD_DIV(BD),
        .STABLE_MS(SMS), .PAUSE_MS(PMS)
    ) u_dtmf_digit_serializer (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .tone_det(tone_det),
        .tone_code(tone_code), .dvalid_n(dvalid_n), .sdata_out(sdata_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: counters in milliseconds and bit slots
    int  m_pre = 0, m_cand = 0, m_run = 0, m_quiet = 0, m_bit = 0, m_baud = 0;
    bit  m_have = 0, m_armed = 1, m_busy = 0;
    bit [9:0] m_frame = '0;

    always @(posedge clk) begin
        bit tick, acc;
        if (!rst_n || pwr_down) begin
            m_pre = 0; m_cand = 0; m_run = 0; m_quiet = 0; m_bit = 0; m_baud = 0;
            m_have = 0; m_armed = 1; m_busy = 0;
        end else begin
            tick = (m_pre == CPM - 1);
            acc  = m_armed && m_have && (m_run == SMS) && !m_busy;
            m_pre = tick ? 0 : m_pre + 1;
            if (m_busy) begin
                if (m_baud == BD - 1) begin
                    m_baud = 0;
                    if (m_bit == 9) m_busy = 0; else m_bit++;
                end else m_baud++;
            end else if (acc) begin
                m_busy = 1; m_bit = 0; m_baud = 0;
                m_frame = {1'b1, 4'((16 - m_cand) % 16), 4'(m_cand), 1'b0};
            end
            if (tone_det) begin
                m_quiet = 0;
                if (!m_have || int'(tone_code) != m_cand) begin
                    m_cand = int'(tone_code); m_have = 1; m_run = 0;
                end else if (tick && m_run < SMS) m_run++;
            end else begin
                if (m_quiet == PMS) m_armed = 1;
                m_have = 0; m_run = 0;
                if (tick && m_quiet < PMS) m_quiet++;
            end
            if (acc) m_armed = 0;
        end
    end

    // per-cycle comparison and independent frame decoding
    bit prev_dvn = 1;
    bit rx_on = 0;
    int rx_k = 0;
    bit [9:0] rx_bits;

    always @(posedge clk) begin
        bit e_dvn, e_sdo;
        #5;
        if (rst_n) begin
            e_dvn = pwr_down | !m_busy;
            e_sdo = pwr_down | (m_busy ? m_frame[m_bit] : 1'b1);
            check(dvalid_n == e_dvn, {cur_req, " dvalid_n"}, dvalid_n, e_dvn);
            check(sdata_out == e_sdo, {cur_req, " sdata_out"}, sdata_out, e_sdo);
            if (prev_dvn && !dvalid_n) begin rx_on = 1; rx_k = 0; end
            if (rx_on) begin
                if (dvalid_n) begin
                    rx_on = 0;
                    if (rx_k == 10 * BD) begin
                        frames++;
                        check(rx_bits[0] == 1'b0, "R3 start bit", rx_bits[0], 0);
                        check(int'(rx_bits[4:1]) == cur_code, "R4 data nibble", rx_bits[4:1], cur_code);
                        check(int'(rx_bits[8:5]) == (16 - cur_code) % 16, "R5 check nibble",
                              rx_bits[8:5], (16 - cur_code) % 16);
                        check(rx_bits[9] == 1'b1, "R4 stop bit", rx_bits[9], 1);
                    end
                end else begin
                    if (rx_k % BD == BD / 2) rx_bits[rx_k / BD] = sdata_out;
                    rx_k++;
                end
            end
            prev_dvn = dvalid_n;
        end
    end

    task automatic wait_ms(input int n);
        repeat (n * CPM) @(negedge clk);
    endtask

    task automatic press(input int code, input int ms);
        @(negedge clk);
        tone_det = 1'b1; tone_code = 4'(code); cur_code = code;
        wait_ms(ms);
    endtask

    task automatic quiet(input int ms);
        @(negedge clk);
        tone_det = 1'b0;
        wait_ms(ms);
    endtask

    task automatic expect_frames(input int n, input string req);
        check(frames == n, {req, " frame count"}, frames, n);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dvalid_n == 1'b1, "R9 reset dvalid_n", dvalid_n, 1);
        check(sdata_out == 1'b1, "R9 reset sdata_out", sdata_out, 1);
        rst_n = 1'b1;
        quiet(25);
        cur_req = "R1"; press(5, 60); expect_frames(1, "R1");
        cur_req = "R7"; wait_ms(30); expect_frames(1, "R7");
        cur_req = "R4"; quiet(25); press(10, 55); quiet(25); expect_frames(2, "R4");
        cur_req = "R1"; press(3, 30); quiet(25); expect_frames(2, "R1 short tone");
        cur_req = "R2"; press(7, 55); quiet(10); press(9, 60); expect_frames(3, "R2 short gap");
        quiet(25); press(9, 55); quiet(25); expect_frames(4, "R2 after pause");
        cur_req = "R10"; press(4, 25); press(8, 25); expect_frames(4, "R10 restart");
        wait_ms(30); quiet(25); expect_frames(5, "R10 new code");
        cur_req = "R5"; press(0, 55); quiet(25); expect_frames(6, "R5 zero");
        press(15, 55); quiet(25); expect_frames(7, "R5 fifteen");
        cur_req = "R6"; press(2, 55); quiet(25); expect_frames(8, "R6");
        cur_req = "R8"; press(6, 43);
        check(dvalid_n == 1'b0, "R8 frame running", dvalid_n, 0);
        @(negedge clk); pwr_down = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(dvalid_n == 1'b1 && sdata_out == 1'b1, "R8 outputs high", {dvalid_n, sdata_out}, 3);
        end
        pwr_down = 1'b0; tone_det = 1'b0;
        wait_ms(25);
        expect_frames(8, "R8 abandoned");
        cur_req = "R9";
        check(dvalid_n == 1'b1 && sdata_out == 1'b1, "R9 idle", {dvalid_n, sdata_out}, 3);
        finish_run();
    end
endmodule